// File: doc/BRIEF.md
# Split Decade Counter with Preset-to-Nine

This block is a four-bit counter built from two sections, each with its own count input. The low section is a divide-by-two stage that drives bit 0. The upper section is a divide-by-five stage that drives bits 3..1. Each count input is brought into the single system clock domain through a synchroniser. Each high-to-low transition that the synchroniser detects advances its section by one step.

Two input pairs control the counter outside of counting. Each pair only acts when both of its inputs are high. The clear pair drives the whole counter to zero. The nine pair loads the value nine, and it overrides the clear pair. The counter does not advance while either pair is fully asserted.

The counter has two useful modes, set up by external wiring. If bit 0 drives the upper count input and pulses arrive at the low input, the counter follows the decimal 0..9 sequence. If bit 3 drives the low count input and pulses arrive at the upper input, the counter follows a five-by-two sequence, and bit 0 becomes a square wave with an even duty cycle at one tenth of the pulse rate.

Top module: `bcd_split_counter`

## Requirements
- R1: While rst_ni is low, q_o is 4'b0000.
- R2: Each falling edge on cnt2_i toggles q_o[0] and leaves q_o[3:1] unchanged.
- R3: Each falling edge on cnt5_i steps q_o[3:1] through 0,1,2,3,4 and back to 0, and leaves q_o[0] unchanged.
- R4: When clr_a_i and clr_b_i are both high and the nine pair is not both high, q_o becomes 4'b0000 on the next clock edge and stays there. A single high clear input has no effect.
- R5: When nine_a_i and nine_b_i are both high, q_o becomes 4'b1001 on the next clock edge, whatever the clear inputs are. A single high nine input has no effect.
- R6: While either control pair is fully high, falling edges on the count inputs are ignored.
- R7: With q_o[0] fed to cnt5_i and pulses at cnt2_i, q_o counts 0 to 9 in binary and then wraps to 0.
- R8: With q_o[3] fed to cnt2_i and pulses at cnt5_i, {q_o[0],q_o[3:1]} runs 0,1,2,3,4,8,9,10,11,12 and repeats. q_o[0] spends five pulses low and five pulses high.
- R9: A section updates at the third rising clock edge that samples its count input low after a high level. A rising edge on a count input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cnt2_i | input | 1 | Count input of the divide-by-two section (asynchronous) |
| cnt5_i | input | 1 | Count input of the divide-by-five section (asynchronous) |
| clr_a_i | input | 1 | Clear pair, first input |
| clr_b_i | input | 1 | Clear pair, second input |
| nine_a_i | input | 1 | Preset-to-nine pair, first input |
| nine_b_i | input | 1 | Preset-to-nine pair, second input |
| q_o | output | 4 | Count value, bit 0 from divide-by-two, bits 3..1 from divide-by-five |

## Verification
If the divide-by-five section ever entered one of its three unused codes, q_o[3:1] would show 5, 6 or 7. In the chained modes this shows up within one pulse as a value the decimal or five-by-two sequence never holds. A lost or doubled edge from a synchroniser appears at the ports two clock cycles later as a skipped or repeated step. Because the count is walked through both wired modes, the error also moves the wrap point of the sequence. If the clear or preset priority were wrong, the value seen one edge after the pair is asserted would be wrong.

// File: rtl/bcd_split_pkg.sv
package bcd_split_pkg;
  localparam int unsigned QUIN_W   = 3;
  localparam int unsigned CNT_W    = QUIN_W + 1;
  localparam logic [QUIN_W-1:0] QUIN_LAST = 3'd4;
  localparam logic [CNT_W-1:0]  NINE_VAL  = 4'b1001;
  typedef logic [QUIN_W-1:0] quin_t;
  typedef logic [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/bcd_edge_sync.sv
module bcd_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic fall_o
);
  // sh[0] is the first synchroniser flop; sh[STAGES] holds the previous synced value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];

  // R9
  fall_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/bcd_div2.sv
module bcd_div2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic clr_i,
  input  logic set_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
    else if (adv_i) q_o <= ~q_o;
  end

  // R2
  toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clr_i && !set_i) |=> (q_o != $past(q_o)));
endmodule

// File: rtl/bcd_div5.sv
module bcd_div5
  import bcd_split_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  adv_i,
  input  logic  clr_i,
  input  logic  set_i,
  output quin_t q_o
);
  quin_t nxt;

  always_comb begin
    nxt = q_o;
    if (set_i)                nxt = NINE_VAL[CNT_W-1:1];
    else if (clr_i)           nxt = '0;
    else if (adv_i)           nxt = (q_o >= QUIN_LAST) ? '0 : q_o + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= nxt;
  end

  // R3
  quin_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o <= QUIN_LAST);
  // R3
  quin_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clr_i && !set_i && q_o == QUIN_LAST) |=> (q_o == '0));
endmodule

// File: rtl/bcd_split_counter.sv
module bcd_split_counter
  import bcd_split_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt2_i,
  input  logic             cnt5_i,
  input  logic             clr_a_i,
  input  logic             clr_b_i,
  input  logic             nine_a_i,
  input  logic             nine_b_i,
  output logic [CNT_W-1:0] q_o
);
  localparam int unsigned NCH = 2;

  logic [NCH-1:0] cnt_in, fall;
  logic           set_pair, clr_pair;
  logic           q2;
  quin_t          q5;

  assign cnt_in   = {cnt5_i, cnt2_i};
  assign set_pair = nine_a_i & nine_b_i;
  assign clr_pair = clr_a_i & clr_b_i & ~set_pair;

  for (genvar i = 0; i < NCH; i++) begin : g_sync
    bcd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (cnt_in[i]),
      .fall_o (fall[i])
    );
  end

  bcd_div2 u_div2 (
    .clk_i (clk_i), .rst_ni (rst_ni), .adv_i (fall[0]),
    .clr_i (clr_pair), .set_i (set_pair), .q_o (q2)
  );

  bcd_div5 u_div5 (
    .clk_i (clk_i), .rst_ni (rst_ni), .adv_i (fall[1]),
    .clr_i (clr_pair), .set_i (set_pair), .q_o (q5)
  );

  assign q_o = {q5, q2};

  // R1
  reset_zero_chk: assert property (@(posedge clk_i) !rst_ni |-> q_o == '0);
  // R5
  nine_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nine_a_i && nine_b_i) |=> (q_o == NINE_VAL));
  // R4
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_a_i && clr_b_i && !(nine_a_i && nine_b_i)) |=> (q_o == '0));
  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall == '0 && !(nine_a_i && nine_b_i) && !(clr_a_i && clr_b_i)) |=> $stable(q_o));
endmodule

// File: tb/bcd_split_counter_bench.sv
module bcd_split_counter_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       a_drv = 1'b0, b_drv = 1'b0;
  logic       clr_a = 1'b0, clr_b = 1'b0, nine_a = 1'b0, nine_b = 1'b0;
  logic       bcd_mode = 1'b0, bq_mode = 1'b0;
  logic       a_pin, b_pin;
  logic [3:0] q;
  int         checks = 0, failures = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  assign a_pin = bq_mode  ? q[3] : a_drv;
  assign b_pin = bcd_mode ? q[0] : b_drv;

  bcd_split_counter u_bcd_split_counter (
    .clk_i (clk), .rst_ni (rst_ni), .cnt2_i (a_pin), .cnt5_i (b_pin),
    .clr_a_i (clr_a), .clr_b_i (clr_b), .nine_a_i (nine_a), .nine_b_i (nine_b),
    .q_o (q)
  );

  // op[5:4]: 0 pulse A, 1 pulse B, 2 clear pair, 3 nine pair; exp[3:0]
  localparam logic [5:0] VEC [13] = '{
    {2'd0, 4'b0001}, {2'd0, 4'b0000}, {2'd1, 4'b0010}, {2'd1, 4'b0100},
    {2'd1, 4'b0110}, {2'd1, 4'b1000}, {2'd1, 4'b0000}, {2'd0, 4'b0001},
    {2'd3, 4'b1001}, {2'd1, 4'b0001}, {2'd2, 4'b0000}, {2'd1, 4'b0010},
    {2'd0, 4'b0011}
  };

  task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_a();
    a_drv = 1'b1; wait_clk(4); a_drv = 1'b0; wait_clk(10);
  endtask

  task automatic pulse_b();
    b_drv = 1'b1; wait_clk(4); b_drv = 1'b0; wait_clk(10);
  endtask

  task automatic do_clear();
    clr_a = 1'b1; clr_b = 1'b1; wait_clk(3); clr_a = 1'b0; clr_b = 1'b0; wait_clk(1);
  endtask

  task automatic do_nine();
    nine_a = 1'b1; nine_b = 1'b1; wait_clk(3); nine_a = 1'b0; nine_b = 1'b0; wait_clk(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wait_clk(3);
    chk("R1 reset", q, 4'b0000);
    rst_ni = 1'b1;
    wait_clk(2);
    chk("R1 after release", q, 4'b0000);

    // table walk, independent sections (R2, R3, R4, R5)
    for (int i = 0; i < 13; i++) begin
      case (VEC[i][5:4])
        2'd0: pulse_a();
        2'd1: pulse_b();
        2'd2: do_clear();
        default: do_nine();
      endcase
      chk($sformatf("R2/R3/R4/R5 vec%0d", i), q, VEC[i][3:0]);
    end

    // R9 latency and rising-edge immunity; q = 0011
    a_drv = 1'b1; wait_clk(4);
    chk("R9 rising no effect", q, 4'b0011);
    a_drv = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk("R9 not before third edge", q, 4'b0011);
    @(posedge clk); #1;
    chk("R9 at third edge", q, 4'b0010);
    wait_clk(4);

    // R4 single clear input ignored, pair holds zero through pulses
    clr_a = 1'b1; pulse_b();
    chk("R4 single clear ignored", q, 4'b0100);
    clr_b = 1'b1; wait_clk(2);
    chk("R4 pair clears", q, 4'b0000);
    pulse_a(); pulse_b();
    chk("R6 counts ignored under clear", q, 4'b0000);
    clr_a = 1'b0; clr_b = 1'b0; wait_clk(1);

    // R5 nine overrides clear; single nine ignored
    nine_a = 1'b1; wait_clk(2);
    chk("R5 single nine ignored", q, 4'b0000);
    clr_a = 1'b1; clr_b = 1'b1; nine_b = 1'b1; wait_clk(1);
    chk("R5 nine beats clear", q, 4'b1001);
    pulse_a();
    chk("R6 counts ignored under nine", q, 4'b1001);
    nine_a = 1'b0; nine_b = 1'b0; wait_clk(1);
    chk("R4 clear after nine drops", q, 4'b0000);
    clr_a = 1'b0; clr_b = 1'b0; wait_clk(1);

    // R7 decimal mode
    bcd_mode = 1'b1; wait_clk(4);
    for (int k = 1; k <= 12; k++) begin
      pulse_a();
      chk($sformatf("R7 step%0d", k), q, 4'(k % 10));
    end
    bcd_mode = 1'b0;
    do_clear();

    // R8 five-by-two mode
    bq_mode = 1'b1; wait_clk(4);
    for (int k = 1; k <= 12; k++) begin
      pulse_b();
      chk($sformatf("R8 step%0d", k), q, {3'(k % 5), 1'((k / 5) % 2)});
    end
    bq_mode = 1'b0;

    // R1 asynchronous reset mid-count
    do_nine();
    rst_ni = 1'b0; #1;
    chk("R1 async reset", q, 4'b0000);
    wait_clk(1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule